// File: doc/BRIEF.md
# Add/Subtract Unit with Carry Held in the Program Counter

This execution unit performs 32-bit addition, subtraction, unsigned and signed comparison, and unsigned and signed minimum/maximum for a small core. The core has no status register. The carry or borrow of each operation is stored in bit 0 of the program counter. Instructions are 2-byte aligned, so that bit is never used for addressing. The unit owns the program counter register. Other instructions can read the flag through `carry_flag` or through `pc_q`, but only this unit, or a context restore, can change it.

An operation is issued for one cycle with `op_valid`, an opcode, two operands and a destination index. Results are registered. A result bound for an ordinary register comes out on `res_data`/`res_dst` with a one-cycle `res_we` pulse. A result bound for the PC replaces PC bits 31:1, and bit 0 takes the new carry. Compares change only the carry bit. A relative jump is an ADD whose first operand is the current PC and whose destination is the PC. Because the operand includes the stored carry in bit 0, an odd offset lets that carry propagate into the target address.

Top module: `asu_pc_carry`

## Requirements
- R1: Opcode 0 (ADD) produces a+b modulo 2^32, and its carry is the carry out of bit 31.
- R2: Opcode 1 (SUB) produces a-b modulo 2^32, and its carry is 1 exactly when a < b as unsigned numbers (a borrow).
- R3: Opcode 4 (MIN) yields the unsigned smaller operand and opcode 5 (MAX) the unsigned larger. Both set the carry to (a < b unsigned), and equal operands give a with carry 0.
- R4: Opcode 6 (SMIN) and opcode 7 (SMAX) treat operands as two's-complement. They yield the signed smaller or larger operand, and the carry is (a < b signed).
- R5: Opcode 2 (CMPU) sets the carry to (a < b unsigned) and opcode 3 (CMPS) sets it to (a < b signed). Neither raises `res_we` nor changes PC bits 31:1, whatever `dst_sel` holds.
- R6: A compare of a value with itself leaves the carry bit at 0.
- R7: A non-compare operation whose `dst_sel` equals the PC index (default 0) loads PC bits 31:1 from the result and PC bit 0 from the carry, with `res_we` low.
- R8: A non-compare operation with any other destination pulses `res_we` with `res_data` and `res_dst`. It leaves PC bits 31:1 unchanged and writes the carry into PC bit 0.
- R9: An ADD of the current `pc_q` (bit 0 included) and an odd offset into the PC gives a target that differs by the stored carry value.
- R10: `ctx_valid` loads all 32 PC bits from `ctx_pc`, takes priority over an operation issued in the same cycle, and discards that operation.
- R11: Opcodes 8 to 15 are ignored: no `res_we` and no PC change.
- R12: Synchronous reset clears the PC (carry included), `res_data`, `res_dst` and `res_we`.
- R13: All outputs reflect an operation issued in cycle N at the clock edge that ends cycle N, and operations may be issued back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Issue an operation this cycle |
| op_code | input | 4 | Operation code |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| dst_sel | input | 5 | Destination register index |
| ctx_valid | input | 1 | Context restore of the full PC |
| ctx_pc | input | 32 | PC value to restore, bit 0 included |
| res_we | output | 1 | Register write strobe for a non-PC destination |
| res_dst | output | 5 | Destination index of the write |
| res_data | output | 32 | Result value |
| pc_q | output | 32 | Program counter; bit 0 is the carry |
| carry_flag | output | 1 | Current carry (PC bit 0) |

## Verification
Every result is due exactly one clock edge after the cycle in which its operation or context restore was presented: `res_we`, `res_data`, `res_dst` and the whole of `pc_q` change together at that edge. The driver stamps each expected item with the cycle count of the following edge. The monitor pops an item only in the half-cycle after that edge, so back-to-back operations are each compared against their own slot. Relative-jump cases take the first operand from the bench's own PC model, so the carry-dependent target is predicted from the requirement alone.

// File: rtl/asu_pkg.sv
package asu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMPU = 4'd2,
        OP_CMPS = 4'd3,
        OP_MIN  = 4'd4,
        OP_MAX  = 4'd5,
        OP_SMIN = 4'd6,
        OP_SMAX = 4'd7
    } asu_op_e;

    typedef struct packed {
        logic legal;
        logic is_cmp;
        logic is_add;
        logic use_signed;
        logic pick_max;
        logic is_select;
    } asu_dec_t;

    typedef struct packed {
        logic ult;
        logic slt;
        logic add_cout;
    } asu_flags_t;

    function automatic asu_dec_t asu_decode(input logic [3:0] code);
        asu_dec_t d;
        d = '0;
        d.legal = (code[3] == 1'b0);
        case (code)
            OP_ADD:  d.is_add = 1'b1;
            OP_CMPU: d.is_cmp = 1'b1;
            OP_CMPS: begin d.is_cmp = 1'b1; d.use_signed = 1'b1; end
            OP_MIN:  d.is_select = 1'b1;
            OP_MAX:  begin d.is_select = 1'b1; d.pick_max = 1'b1; end
            OP_SMIN: begin d.is_select = 1'b1; d.use_signed = 1'b1; end
            OP_SMAX: begin d.is_select = 1'b1; d.use_signed = 1'b1; d.pick_max = 1'b1; end
            default: ;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/asu_arith.sv
module asu_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic               do_sub,
    output logic [DATA_W-1:0]  sum,
    output asu_pkg::asu_flags_t flags
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] b_eff;
    logic [DATA_W:0]   wide;

    always_comb begin
        b_eff = do_sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
        sum   = wide[MSB:0];
        flags.add_cout = wide[DATA_W];
        // subtraction borrows when no carry leaves the top bit
        flags.ult = ~wide[DATA_W];
        // differing signs decide directly, otherwise the unsigned borrow does
        flags.slt = (a[MSB] ^ b[MSB]) ? a[MSB] : ~wide[DATA_W];
    end
endmodule

// File: rtl/asu_result_sel.sv
module asu_result_sel #(
    parameter int DATA_W = 32
) (
    input  asu_pkg::asu_dec_t   dec,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic [DATA_W-1:0]   sum,
    input  asu_pkg::asu_flags_t flags,
    output logic [DATA_W-1:0]   result,
    output logic                carry
);
    logic lt;

    always_comb begin
        lt = dec.use_signed ? flags.slt : flags.ult;
        if (dec.is_add) begin
            carry = flags.add_cout;
        end else begin
            carry = lt;
        end
        if (dec.is_select) begin
            result = (lt ^ dec.pick_max) ? a : b;
        end else begin
            result = sum;
        end
    end
endmodule

// File: rtl/asu_pc_reg.sv
module asu_pc_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctx_load,
    input  logic [DATA_W-1:0] ctx_value,
    input  logic              flag_upd,
    input  logic              addr_upd,
    input  logic [DATA_W-1:0] new_value,
    input  logic              new_carry,
    output logic [DATA_W-1:0] pc
);
    localparam int MSB = DATA_W - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else if (ctx_load) begin
            pc <= ctx_value;
        end else if (flag_upd) begin
            pc[0] <= new_carry;
            if (addr_upd) begin
                pc[MSB:1] <= new_value[MSB:1];
            end
        end
    end
endmodule

// File: rtl/asu_pc_carry.sv
module asu_pc_carry #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int PC_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IDX_W-1:0]  dst_sel,
    input  logic              ctx_valid,
    input  logic [DATA_W-1:0] ctx_pc,
    output logic              res_we,
    output logic [IDX_W-1:0]  res_dst,
    output logic [DATA_W-1:0] res_data,
    output logic [DATA_W-1:0] pc_q,
    output logic              carry_flag
);
    import asu_pkg::*;

    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    asu_dec_t          dec;
    asu_flags_t        flags;
    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] result;
    logic              carry;
    logic              accept;
    logic              to_pc;

    always_comb begin
        dec    = asu_decode(op_code);
        accept = op_valid && !ctx_valid && dec.legal;
        to_pc  = (dst_sel == PC_SEL) && !dec.is_cmp;
    end

    asu_arith #(.DATA_W(DATA_W)) arith_i (
        .a      (opnd_a),
        .b      (opnd_b),
        .do_sub (!dec.is_add),
        .sum    (sum),
        .flags  (flags)
    );

    asu_result_sel #(.DATA_W(DATA_W)) sel_i (
        .dec    (dec),
        .a      (opnd_a),
        .b      (opnd_b),
        .sum    (sum),
        .flags  (flags),
        .result (result),
        .carry  (carry)
    );

    asu_pc_reg #(.DATA_W(DATA_W)) pc_i (
        .clk       (clk),
        .rst       (rst),
        .ctx_load  (ctx_valid),
        .ctx_value (ctx_pc),
        .flag_upd  (accept),
        .addr_upd  (to_pc),
        .new_value (result),
        .new_carry (carry),
        .pc        (pc_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_we   <= 1'b0;
            res_dst  <= '0;
            res_data <= '0;
        end else begin
            res_we <= accept && !dec.is_cmp && !to_pc;
            if (accept) begin
                res_dst  <= dst_sel;
                res_data <= result;
            end
        end
    end

    assign carry_flag = pc_q[0];
endmodule

// File: rtl/asu_pc_carry_chk.sv
module asu_pc_carry_chk #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5,
    parameter int PC_IDX = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_code,
    input logic [DATA_W-1:0] opnd_a,
    input logic [DATA_W-1:0] opnd_b,
    input logic [IDX_W-1:0]  dst_sel,
    input logic              ctx_valid,
    input logic [DATA_W-1:0] ctx_pc,
    input logic              res_we,
    input logic [IDX_W-1:0]  res_dst,
    input logic [DATA_W-1:0] pc_q
);
    localparam logic [IDX_W-1:0] PC_SEL = IDX_W'(PC_IDX);

    logic cmp_now;
    logic bad_now;
    assign cmp_now = op_valid && !ctx_valid && (op_code == 4'd2 || op_code == 4'd3);
    assign bad_now = op_valid && !ctx_valid && op_code[3];

    // R5: compares never write a register nor move the address bits
    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        cmp_now |=> !res_we && $stable(pc_q[DATA_W-1:1]));

    // R6: a compare of equal operands leaves carry clear
    a_r6_self_cmp_clear: assert property (@(posedge clk) disable iff (rst)
        (cmp_now && opnd_a == opnd_b) |=> !pc_q[0]);

    // R7: a PC-bound write never shows up as a register write
    a_r7_pc_dst_no_we: assert property (@(posedge clk) disable iff (rst)
        res_we |-> res_dst != PC_SEL);

    // R10: context restore loads every PC bit
    a_r10_ctx_load: assert property (@(posedge clk) disable iff (rst)
        ctx_valid |=> (pc_q == $past(ctx_pc)) && !res_we);

    // R11: undefined opcodes change nothing
    a_r11_illegal_ignored: assert property (@(posedge clk) disable iff (rst)
        bad_now |=> $stable(pc_q) && !res_we);

    // R12: reset clears PC and the write strobe
    a_r12_reset_state: assert property (@(posedge clk)
        rst |=> (pc_q == '0) && !res_we);

    // R13: no write strobe without an operation one cycle earlier
    a_r13_we_needs_op: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_we);
endmodule

bind asu_pc_carry asu_pc_carry_chk #(
    .DATA_W (DATA_W),
    .IDX_W  (IDX_W),
    .PC_IDX (PC_IDX)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .dst_sel   (dst_sel),
    .ctx_valid (ctx_valid),
    .ctx_pc    (ctx_pc),
    .res_we    (res_we),
    .res_dst   (res_dst),
    .pc_q      (pc_q)
);

// File: tb/asu_pc_carry_tb_top.sv
module asu_pc_carry_tb_top;

    typedef struct {
        int          due;
        logic        we;
        logic [4:0]  dst;
        logic [31:0] data;
        logic [31:0] pc;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [4:0]  dst_sel = '0;
    logic        ctx_valid = 1'b0;
    logic [31:0] ctx_pc = '0;
    logic        res_we;
    logic [4:0]  res_dst;
    logic [31:0] res_data;
    logic [31:0] pc_q;
    logic        carry_flag;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    logic [31:0] m_pc = '0;
    exp_t q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    asu_pc_carry dut_i (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .dst_sel(dst_sel),
        .ctx_valid(ctx_valid), .ctx_pc(ctx_pc), .res_we(res_we),
        .res_dst(res_dst), .res_data(res_data), .pc_q(pc_q),
        .carry_flag(carry_flag)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Requirement-level model of one operation
    task automatic drive_op(input logic [3:0] code, input logic [31:0] a,
                            input logic [31:0] b, input logic [4:0] dst,
                            input string tag);
        exp_t e;
        logic ult, slt, c, cmp, legal;
        logic [32:0] s33;
        logic [31:0] r;
        ult = a < b;
        slt = $signed(a) < $signed(b);
        s33 = {1'b0, a} + {1'b0, b};
        cmp = 1'b0; legal = 1'b1; r = a - b; c = ult;
        case (code)
            4'd0: begin r = s33[31:0]; c = s33[32]; end
            4'd1: ;
            4'd2: cmp = 1'b1;
            4'd3: begin cmp = 1'b1; c = slt; end
            4'd4: r = ult ? a : b;
            4'd5: r = ult ? b : a;
            4'd6: begin r = slt ? a : b; c = slt; end
            4'd7: begin r = slt ? b : a; c = slt; end
            default: legal = 1'b0;
        endcase
        e.due = cyc + 1; e.tag = tag; e.we = 1'b0; e.dst = dst; e.data = r;
        if (legal) begin
            if (!cmp && dst == 5'd0) m_pc = {r[31:1], c};
            else m_pc = {m_pc[31:1], c};
            e.we = !cmp && dst != 5'd0;
        end
        e.pc = m_pc;
        q.push_back(e);
        op_valid = 1'b1; op_code = code; opnd_a = a; opnd_b = b; dst_sel = dst;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic drive_ctx(input logic [31:0] v, input bit with_op);
        exp_t e;
        m_pc = v;
        e.due = cyc + 1; e.tag = "R10"; e.we = 1'b0; e.dst = 5'd0;
        e.data = '0; e.pc = v;
        q.push_back(e);
        ctx_valid = 1'b1; ctx_pc = v;
        op_valid = with_op; op_code = 4'd0; opnd_a = 32'h11; opnd_b = 32'h22;
        dst_sel = 5'd3;
        @(negedge clk);
        ctx_valid = 1'b0; op_valid = 1'b0;
    endtask

    // Monitor: pop each item in the half cycle after its due edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "res_we", {31'd0, res_we}, {31'd0, e.we});
            check(e.tag, "pc_q", pc_q, e.pc);
            if (e.we) begin
                check(e.tag, "res_data", res_data, e.data);
                check(e.tag, "res_dst", {27'd0, res_dst}, {27'd0, e.dst});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        check("R12", "pc_q", pc_q, 32'h0);
        check("R12", "res_we", {31'd0, res_we}, 32'd0);
        check("R12", "res_data", res_data, 32'h0);
        // R1 / R8 / R13 back to back
        drive_op(4'd0, 32'd5, 32'd7, 5'd3, "R1");
        drive_op(4'd0, 32'hFFFF_FFFF, 32'd2, 5'd4, "R1");
        drive_op(4'd1, 32'd3, 32'd5, 5'd2, "R2");
        drive_op(4'd1, 32'd9, 32'd4, 5'd6, "R8");
        // R5: signed vs unsigned ordering with top bit set
        drive_op(4'd2, 32'h8000_0000, 32'd1, 5'd0, "R5");
        drive_op(4'd3, 32'h8000_0000, 32'd1, 5'd0, "R5");
        drive_op(4'd2, 32'd1, 32'd2, 5'd7, "R5");
        // R6: self compare clears a set carry
        drive_op(4'd2, 32'h1234_5678, 32'h1234_5678, 5'd0, "R6");
        drive_op(4'd3, 32'd1, 32'd2, 5'd0, "R5");
        drive_op(4'd3, 32'hF000_0001, 32'hF000_0001, 5'd0, "R6");
        // R3 / R4
        drive_op(4'd4, 32'h8000_0000, 32'd1, 5'd9, "R3");
        drive_op(4'd5, 32'h8000_0000, 32'd1, 5'd9, "R3");
        drive_op(4'd4, 32'd7, 32'd7, 5'd10, "R3");
        drive_op(4'd6, 32'h8000_0000, 32'd1, 5'd11, "R4");
        drive_op(4'd7, 32'h8000_0000, 32'd1, 5'd11, "R4");
        drive_op(4'd6, 32'd3, 32'hFFFF_FFFE, 5'd12, "R4");
        // R7: PC destination keeps new carry in bit 0
        drive_op(4'd0, 32'h0000_1000, 32'h0000_0203, 5'd0, "R7");
        drive_op(4'd0, 32'hFFFF_FFF0, 32'h0000_0021, 5'd0, "R7");
        // R9: odd relative jump under carry 0 then carry 1
        drive_op(4'd2, 32'd4, 32'd4, 5'd0, "R9");
        drive_op(4'd0, m_pc, 32'h11, 5'd0, "R9");
        drive_op(4'd2, 32'd1, 32'd2, 5'd0, "R9");
        drive_op(4'd0, m_pc, 32'h11, 5'd0, "R9");
        // R10: context restore, alone and over an operation
        drive_ctx(32'h0000_4567, 1'b1);
        drive_ctx(32'h0000_0200, 1'b0);
        // R11: undefined opcodes
        drive_op(4'd9, 32'd1, 32'd2, 5'd3, "R11");
        drive_op(4'd15, 32'd0, 32'd5, 5'd0, "R11");
        repeat (3) @(negedge clk);
        if (q.size() != 0) check("R13", "pending", q.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                check("R13", "watchdog", 32'd1, 32'd0);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule